// File: doc/BRIEF.md
# Dual Interval Timers with Composite-Sine Key Trigger

This block holds the two interval timers of an FM sound generator. Both count upward from a host-written start value. When a timer's count passes its all-ones value, the counter loads the start value again by itself, and the timer raises a sticky overflow flag. The flag is raised only when that timer's enable bit is set. The host clears a flag with a one-cycle clear pulse. The interrupt output is high while either flag is set.

Timing comes from the chip's sub-cycle counter, which is an input here. Start requests are taken only in one sub-cycle (the load phase). Counting happens only in another (the step phase). Timer A has a 10-bit count and advances once per sample period. Timer B has an 8-bit count and advances once every 16 sample periods, through a free-running prescaler.

When the third channel is in composite-sine mode, a start or overflow of timer A also produces a key-on pulse for all operators of that channel.

Top module: `fmt_interval_timers`

## Requirements
- R1: A timer starts only on a rising edge of its load input that is present in a cycle where `phase_i` equals 2. A load pulse that does not cover such a cycle has no effect. Lowering load stops the counting from the next phase-2 cycle.
- R2: While started, timer A adds 1 in every cycle with `phase_i` == 1. It overflows after 1024−R such steps, where R is `ta_reload_i`. It then reloads R and overflows again every 1024−R steps. Its flag rises right after the overflowing phase-1 cycle.
- R3: While `ta_force_i` is 1, timer A adds 1 every clock cycle, with or without a start. With the force input at 0 and no start, timer A does not move.
- R4: Timer B has a 16-step prescaler. The prescaler advances in every phase-1 cycle from reset and ticks in the phase-1 cycles whose index since reset is 15 modulo 16. Timer B adds 1 on each tick while started, so it overflows after 256−R ticks and then every 16·(256−R) phase-1 cycles.
- R5: An overflow sets a timer's flag only if that timer's enable input is 1. Otherwise the flag keeps its value.
- R6: A one-cycle clear pulse on `ta_clr_i` or `tb_clr_i` makes that flag 0 in the next cycle.
- R7: `irq_o` is 1 exactly when at least one flag is 1.
- R8: With `ch3_mode_i` == 2'b10, a timer A overflow or start drives `csm_key_o` to 1 from the next phase-2 cycle. The pulse lasts one full sample period (24 cycles) and is not gated by the enable input.
- R9: With `ch3_mode_i` other than 2'b10, `csm_key_o` stays 0.
- R10: Under reset, both flags, `irq_o` and `csm_key_o` are 0, and neither timer is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| phase_i | input | 5 | Sub-cycle counter, 0 to 23 |
| ta_reload_i | input | 10 | Timer A start value |
| tb_reload_i | input | 8 | Timer B start value |
| ta_load_i | input | 1 | Timer A run request |
| tb_load_i | input | 1 | Timer B run request |
| ta_en_i | input | 1 | Timer A flag enable |
| tb_en_i | input | 1 | Timer B flag enable |
| ta_clr_i | input | 1 | Timer A flag clear pulse |
| tb_clr_i | input | 1 | Timer B flag clear pulse |
| ta_force_i | input | 1 | Test: step timer A every cycle |
| ch3_mode_i | input | 2 | Third-channel mode, 2'b10 = composite-sine |
| ta_flag_o | output | 1 | Timer A overflow flag |
| tb_flag_o | output | 1 | Timer B overflow flag |
| irq_o | output | 1 | Either flag set |
| csm_key_o | output | 1 | Key-on pulse for third-channel operators |

## Verification
Timer A is started close to the top of its range, so that both the first overflow and the auto-reload period are checked against the exact phase-1 index. This separates a correct 1024−R period from off-by-one reload pipelines. Timer B is started at an index that is not aligned to the prescaler. This catches a prescaler that restarts on load or that ticks on the wrong residue. The composite-sine pattern runs with the flag enable off, so a key pulse is shown to come from the raw overflow and not from the flag. A misplaced load pulse, a dropped load and the forced-count test input each show whether counting is gated by the start latch.

// File: rtl/fmt_pkg.sv
`timescale 1ns/1ps
package fmt_pkg;
   typedef enum logic [1:0] {
      CH3_NORMAL  = 2'd0,
      CH3_PEROP   = 2'd1,
      CH3_CSM     = 2'd2,
      CH3_PEROP_B = 2'd3
   } ch3_mode_e;

   function automatic logic phase_is(input logic [7:0] ph, input int unsigned want);
      return ph == want[7:0];
   endfunction
endpackage

// File: rtl/fmt_load_sync.sv
`timescale 1ns/1ps
module fmt_load_sync #(
   parameter int unsigned PHASE_W    = 5,
   parameter int unsigned LOAD_PHASE = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [PHASE_W-1:0] phase_i,
   input  logic               load_i,
   input  logic               ovf_i,
   output logic               lock_o,
   output logic               req_o
);
   localparam logic [PHASE_W-1:0] LOAD_PH = PHASE_W'(LOAD_PHASE);

   logic lock_q;
   logic at_load;

   assign at_load = (phase_i == LOAD_PH);
   // reload request: pending overflow, or a fresh run edge seen in the load phase
   assign req_o   = ovf_i | (at_load & load_i & ~lock_q);
   assign lock_o  = lock_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lock_q <= 1'b0;
      else if (at_load) lock_q <= load_i;
   end
endmodule

// File: rtl/fmt_prescale.sv
`timescale 1ns/1ps
module fmt_prescale #(
   parameter int unsigned PRE_W = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic step_i,
   output logic tick_o
);
   logic [PRE_W-1:0] pre_q;

   assign tick_o = step_i & (&pre_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pre_q <= '0;
      else if (step_i) pre_q <= pre_q + 1'b1;
   end
endmodule

// File: rtl/fmt_counter.sv
`timescale 1ns/1ps
module fmt_counter #(
   parameter int unsigned CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] reload_i,
   input  logic             req_i,
   input  logic             inc_i,
   output logic             carry_o,
   output logic             ovf_o
);
   logic [CNT_W-1:0] cnt_q;
   logic             pend_q;
   logic             ovf_q;
   logic [CNT_W-1:0] base;
   logic [CNT_W:0]   sum;

   always_comb begin
      base    = pend_q ? reload_i : cnt_q;
      sum     = {1'b0, base} + {{CNT_W{1'b0}}, inc_i};
      carry_o = sum[CNT_W];
   end

   assign ovf_o = ovf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         pend_q <= 1'b0;
         ovf_q  <= 1'b0;
      end else begin
         cnt_q  <= sum[CNT_W-1:0];
         pend_q <= req_i;
         ovf_q  <= sum[CNT_W];
      end
   end
endmodule

// File: rtl/fmt_timer.sv
`timescale 1ns/1ps
module fmt_timer #(
   parameter int unsigned PHASE_W    = 5,
   parameter int unsigned LOAD_PHASE = 2,
   parameter int unsigned STEP_PHASE = 1,
   parameter int unsigned CNT_W      = 10,
   parameter int unsigned PRE_W      = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [PHASE_W-1:0] phase_i,
   input  logic [CNT_W-1:0]   reload_i,
   input  logic               load_i,
   input  logic               en_i,
   input  logic               clr_i,
   input  logic               force_i,
   output logic               flag_o,
   output logic               req_o
);
   localparam logic [PHASE_W-1:0] STEP_PH = PHASE_W'(STEP_PHASE);

   logic at_step;
   logic tick;
   logic lock;
   logic carry;
   logic ovf;
   logic flag_q;

   assign at_step = (phase_i == STEP_PH);

   generate
      if (PRE_W == 0) begin : g_direct
         assign tick = at_step;
      end else begin : g_divided
         fmt_prescale #(.PRE_W(PRE_W)) u_pre (
            .clk    (clk),
            .rst_n  (rst_n),
            .step_i (at_step),
            .tick_o (tick)
         );
      end
   endgenerate

   fmt_load_sync #(.PHASE_W(PHASE_W), .LOAD_PHASE(LOAD_PHASE)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .phase_i (phase_i),
      .load_i  (load_i),
      .ovf_i   (ovf),
      .lock_o  (lock),
      .req_o   (req_o)
   );

   fmt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .reload_i (reload_i),
      .req_i    (req_o),
      .inc_i    ((tick & lock) | force_i),
      .carry_o  (carry),
      .ovf_o    (ovf)
   );

   assign flag_o = flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             flag_q <= 1'b0;
      else if (clr_i)         flag_q <= 1'b0;
      else if (carry && en_i) flag_q <= 1'b1;
   end
endmodule

// File: rtl/fmt_interval_timers.sv
`timescale 1ns/1ps
module fmt_interval_timers #(
   parameter int unsigned PHASE_W    = 5,
   parameter int unsigned NUM_PHASES = 24,
   parameter int unsigned LOAD_PHASE = 2,
   parameter int unsigned STEP_PHASE = 1,
   parameter int unsigned TA_W       = 10,
   parameter int unsigned TB_W       = 8,
   parameter int unsigned TB_PRE_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [PHASE_W-1:0] phase_i,
   input  logic [TA_W-1:0]    ta_reload_i,
   input  logic [TB_W-1:0]    tb_reload_i,
   input  logic               ta_load_i,
   input  logic               tb_load_i,
   input  logic               ta_en_i,
   input  logic               tb_en_i,
   input  logic               ta_clr_i,
   input  logic               tb_clr_i,
   input  logic               ta_force_i,
   input  logic [1:0]         ch3_mode_i,
   output logic               ta_flag_o,
   output logic               tb_flag_o,
   output logic               irq_o,
   output logic               csm_key_o
);
   import fmt_pkg::*;

   localparam logic [PHASE_W-1:0] LOAD_PH = PHASE_W'(LOAD_PHASE);

   generate
      if (NUM_PHASES > (1 << PHASE_W)) begin : g_bad_phase_w
         $error("phase counter range exceeds PHASE_W");
      end
      if (LOAD_PHASE >= NUM_PHASES || STEP_PHASE >= NUM_PHASES) begin : g_bad_phase
         $error("load or step phase outside the sub-cycle range");
      end
      if (LOAD_PHASE == STEP_PHASE) begin : g_same_phase
         $error("load and step phases must differ");
      end
      if (TA_W < 2 || TB_W < 2) begin : g_bad_width
         $error("timer widths must be at least 2");
      end
   endgenerate

   logic req_a;
   logic req_b;
   logic csm_q;

   fmt_timer #(
      .PHASE_W(PHASE_W), .LOAD_PHASE(LOAD_PHASE), .STEP_PHASE(STEP_PHASE),
      .CNT_W(TA_W), .PRE_W(0)
   ) u_ta (
      .clk      (clk),
      .rst_n    (rst_n),
      .phase_i  (phase_i),
      .reload_i (ta_reload_i),
      .load_i   (ta_load_i),
      .en_i     (ta_en_i),
      .clr_i    (ta_clr_i),
      .force_i  (ta_force_i),
      .flag_o   (ta_flag_o),
      .req_o    (req_a)
   );

   fmt_timer #(
      .PHASE_W(PHASE_W), .LOAD_PHASE(LOAD_PHASE), .STEP_PHASE(STEP_PHASE),
      .CNT_W(TB_W), .PRE_W(TB_PRE_W)
   ) u_tb (
      .clk      (clk),
      .rst_n    (rst_n),
      .phase_i  (phase_i),
      .reload_i (tb_reload_i),
      .load_i   (tb_load_i),
      .en_i     (tb_en_i),
      .clr_i    (tb_clr_i),
      .force_i  (1'b0),
      .flag_o   (tb_flag_o),
      .req_o    (req_b)
   );

   // key-on level is refreshed once per sample, in the load phase
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) csm_q <= 1'b0;
      else if (phase_i == LOAD_PH)
         csm_q <= (ch3_mode_i == CH3_CSM) & req_a;
   end

   assign csm_key_o = csm_q;
   assign irq_o     = ta_flag_o | tb_flag_o;

   logic unused_b;
   assign unused_b = req_b;
endmodule

// File: rtl/fmt_interval_timers_chk.sv
`timescale 1ns/1ps
module fmt_interval_timers_chk #(
   parameter int unsigned PHASE_W    = 5,
   parameter int unsigned LOAD_PHASE = 2,
   parameter int unsigned STEP_PHASE = 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic [PHASE_W-1:0] phase_i,
   input logic               ta_en_i,
   input logic               tb_en_i,
   input logic               ta_clr_i,
   input logic               tb_clr_i,
   input logic               ta_force_i,
   input logic [1:0]         ch3_mode_i,
   input logic               ta_flag_o,
   input logic               tb_flag_o,
   input logic               irq_o,
   input logic               csm_key_o
);
   localparam logic [PHASE_W-1:0] LOAD_PH = PHASE_W'(LOAD_PHASE);
   localparam logic [PHASE_W-1:0] STEP_PH = PHASE_W'(STEP_PHASE);

   p_ta_rise_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ta_flag_o) |-> ($past(phase_i) == STEP_PH || $past(ta_force_i)));
   p_tb_rise_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tb_flag_o) |-> $past(phase_i) == STEP_PH);
   p_ta_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ta_flag_o) |-> $past(ta_en_i));
   p_tb_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tb_flag_o) |-> $past(tb_en_i));
   p_ta_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ta_clr_i |=> !ta_flag_o);
   p_tb_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tb_clr_i |=> !tb_flag_o);
   p_irq_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> ($rose(ta_flag_o) || $rose(tb_flag_o)));
   p_key_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(csm_key_o) |-> $past(phase_i) == LOAD_PH);
   p_key_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(csm_key_o) |-> $past(ch3_mode_i) == 2'b10);
endmodule

bind fmt_interval_timers fmt_interval_timers_chk #(
   .PHASE_W(PHASE_W), .LOAD_PHASE(LOAD_PHASE), .STEP_PHASE(STEP_PHASE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .phase_i    (phase_i),
   .ta_en_i    (ta_en_i),
   .tb_en_i    (tb_en_i),
   .ta_clr_i   (ta_clr_i),
   .tb_clr_i   (tb_clr_i),
   .ta_force_i (ta_force_i),
   .ch3_mode_i (ch3_mode_i),
   .ta_flag_o  (ta_flag_o),
   .tb_flag_o  (tb_flag_o),
   .irq_o      (irq_o),
   .csm_key_o  (csm_key_o)
);

// File: tb/fmt_interval_timers_tb.sv
`timescale 1ns/1ps
module fmt_interval_timers_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] phase = '0;
   logic [9:0] ta_reload = '0;
   logic [7:0] tb_reload = '0;
   logic ta_load = 0, tb_load = 0, ta_en = 0, tb_en = 0;
   logic ta_clr = 0, tb_clr = 0, ta_force = 0;
   logic [1:0] ch3 = 2'b00;
   logic ta_flag, tb_flag, irq, csm;

   int n_chk = 0, n_fail = 0;
   int p1_cnt = 0, p1_last = -1;
   logic [4:0] ph_edge = '0;
   bit mon_a_en = 1'b1;
   bit csm_seen = 1'b0;
   bit done = 1'b0;
   int qa[$];
   int qb[$];

   always #2.5 clk = ~clk;

   fmt_interval_timers u_dut (
      .clk(clk), .rst_n(rst_n), .phase_i(phase),
      .ta_reload_i(ta_reload), .tb_reload_i(tb_reload),
      .ta_load_i(ta_load), .tb_load_i(tb_load),
      .ta_en_i(ta_en), .tb_en_i(tb_en),
      .ta_clr_i(ta_clr), .tb_clr_i(tb_clr),
      .ta_force_i(ta_force), .ch3_mode_i(ch3),
      .ta_flag_o(ta_flag), .tb_flag_o(tb_flag),
      .irq_o(irq), .csm_key_o(csm)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // sub-cycle driver: changes shortly after each edge, records the value seen at the edge
   initial begin
      forever begin
         @(posedge clk);
         ph_edge = phase;
         if (rst_n && phase == 5'd1) begin
            p1_last = p1_cnt;
            p1_cnt++;
         end
         #0.5 phase = (phase == 5'd23) ? 5'd0 : phase + 5'd1;
      end
   end

   // monitor: pops expected overflow indices when a flag rises
   initial begin
      logic pa, pb;
      pa = 0; pb = 0;
      forever begin
         @(posedge clk);
         #1;
         if (rst_n) begin
            if (ta_flag && !pa && mon_a_en) begin
               if (qa.size() == 0) chk(0, "R2 unexpected A overflow", p1_last, -1);
               else begin
                  int e;
                  e = qa.pop_front();
                  chk(p1_last == e && ph_edge == 5'd1, "R2 A overflow index", p1_last, e);
               end
            end
            if (tb_flag && !pb) begin
               if (qb.size() == 0) chk(0, "R4 unexpected B overflow", p1_last, -1);
               else begin
                  int e;
                  e = qb.pop_front();
                  chk(p1_last == e && ph_edge == 5'd1, "R4 B overflow index", p1_last, e);
               end
            end
            if (csm) csm_seen = 1'b1;
         end
         pa = ta_flag;
         pb = tb_flag;
      end
   end

   task automatic to_phase(input int p);
      do @(negedge clk); while (phase != p[4:0]);
   endtask

   task automatic clear_a();
      @(negedge clk); ta_clr = 1;
      @(negedge clk); ta_clr = 0;
   endtask

   task automatic clear_b();
      @(negedge clk); tb_clr = 1;
      @(negedge clk); tb_clr = 0;
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=0 expected=1");
         summary();
         $finish;
      end
   end

   initial begin
      int n0;
      int t;
      repeat (3) @(negedge clk);
      // R10: reset state
      chk(!ta_flag && !tb_flag, "R10 flags in reset", {ta_flag, tb_flag}, 0);
      chk(!irq && !csm, "R10 irq/key in reset", {irq, csm}, 0);
      rst_n = 1;
      ta_en = 1; tb_en = 1;
      repeat (120) @(negedge clk);
      chk(!ta_flag && !tb_flag, "R1 no run without load", {ta_flag, tb_flag}, 0);

      // R2: timer A first overflow and auto-reload period
      ta_reload = 10'd1020;
      to_phase(2);
      ta_load = 1;
      n0 = p1_cnt;
      qa.push_back(n0 + 3);
      for (int i = 0; i < 200 && !ta_flag; i++) @(negedge clk);
      chk(qa.size() == 0 && ta_flag, "R2 first A overflow seen", qa.size(), 0);
      clear_a();
      chk(!ta_flag, "R6 A flag cleared", ta_flag, 0);
      chk(!irq, "R7 irq low with no flag", irq, 0);
      qa.push_back(n0 + 7);
      for (int i = 0; i < 200 && !ta_flag; i++) @(negedge clk);
      chk(qa.size() == 0 && ta_flag, "R2 reload period", qa.size(), 0);

      // R8/R5: composite-sine key with flag enable off
      @(negedge clk); ta_clr = 1; ta_en = 0; ch3 = 2'b10;
      @(negedge clk); ta_clr = 0;
      for (int i = 0; i < 150 && !csm; i++) @(negedge clk);
      chk(csm && ph_edge == 5'd2 && ((p1_last - (n0 + 3)) % 4) == 0,
          "R8 key after overflow", p1_last, n0 + 11);
      chk(!ta_flag, "R5 no flag with enable off", ta_flag, 0);
      repeat (12) @(negedge clk);
      chk(csm, "R8 key lasts the sample", csm, 1);
      repeat (12) @(negedge clk);
      chk(!csm, "R8 key ends after one sample", csm, 0);

      // R9: other modes give no key
      ch3 = 2'b01;
      csm_seen = 0;
      repeat (150) @(negedge clk);
      chk(!csm_seen, "R9 no key outside mode", csm_seen, 0);

      // R1: dropped load stops, misplaced pulse ignored
      ta_load = 0;
      repeat (50) @(negedge clk);
      ta_en = 1;
      clear_a();
      to_phase(5);
      ta_load = 1;
      repeat (6) @(negedge clk);
      ta_load = 0;
      repeat (200) @(negedge clk);
      chk(!ta_flag, "R1 pulse outside load phase ignored", ta_flag, 0);

      // R3: forced stepping
      mon_a_en = 0;
      ta_reload = 10'd1000;
      ta_force = 1;
      repeat (1100) @(negedge clk);
      chk(ta_flag, "R3 forced count overflows", ta_flag, 1);
      ta_force = 0;
      clear_a();
      repeat (144) @(negedge clk);
      chk(!ta_flag, "R3 idle without force", ta_flag, 0);

      // R4: timer B with prescaler
      tb_reload = 8'd254;
      to_phase(2);
      tb_load = 1;
      t = p1_cnt;
      while ((t % 16) != 15) t++;
      qb.push_back(t + 16);
      for (int i = 0; i < 1200 && !tb_flag; i++) @(negedge clk);
      chk(qb.size() == 0 && tb_flag, "R4 first B overflow seen", qb.size(), 0);
      chk(irq && !ta_flag, "R7 irq from B alone", irq, 1);
      clear_b();
      chk(!tb_flag, "R6 B flag cleared", tb_flag, 0);
      chk(!irq, "R7 irq low after clear", irq, 0);
      qb.push_back(t + 48);
      for (int i = 0; i < 1300 && !tb_flag; i++) @(negedge clk);
      chk(qb.size() == 0 && tb_flag, "R4 B reload period", qb.size(), 0);

      chk(qa.size() == 0 && qb.size() == 0, "R2 R4 no pending items", qa.size() + qb.size(), 0);
      done = 1;
      summary();
      $finish;
   end
endmodule